// File: doc/BRIEF.md
# Hash Message FIFO Drain Sequencer

This block decides, cycle by cycle, when 32-bit message words may leave a 32-entry message FIFO on their way to a SHA-2 compression core. It does not compute hashes. It only reproduces the core's timing. The block also tracks how full the FIFO is, and it blocks writes once the FIFO holds its full capacity.

When a hash starts in keyed (HMAC) mode, the block first holds a key-padding interval. It then pops one word per cycle until a whole block has been read. After that it stalls for the block-processing time and repeats. The block length, the key-padding time and the stall all follow the digest-size setting, which is captured when the hash starts.

The write side follows a valid/ready handshake: a word enters the FIFO on a cycle where `fifo_wvalid` and `fifo_wready` are both high. A writer that holds `fifo_wvalid` while `fifo_wready` is low loses nothing; it simply waits. On the read side, `fifo_rready` is the pop strobe. It rises only when a stored word exists, so every cycle with `fifo_rready` high consumes exactly one word.

Top module: `mfd_drain_seq`

## Requirements
- R1: The FIFO holds at most 32 words. The depth is the write count minus the read count. `fifo_wready` is low exactly when the depth is 32, and a write attempted then leaves the depth at 32.
- R2: `status` carries the following fields:
  - bit 0: idle
  - bit 1: FIFO empty (depth 0)
  - bit 2: FIFO full (depth 32)
  - bit 3: always 0
  - bits 9:4: depth
- R3: A `cfg_digest` value of 4'b0001 at start selects short mode. Every other value selects long mode. Later changes to `cfg_digest` have no effect until the next accepted start.
- R4: `fifo_rready` is high only in the Load state while the FIFO is non-empty. When that holds, one word is popped per cycle.
- R5: A block is 16 pops in short mode and 32 pops in long mode. The cycle after the last pop of a block, the state is Wait.
- R6: After a block, the state stays Wait for 65 cycles in short mode and 81 cycles in long mode, then returns to Load.
- R7: A start accepted with `cfg_hmac` high enters Wait for 81 cycles (short mode) or 113 cycles (long mode) before Load. A start accepted with `cfg_hmac` low enters Load on the next cycle.
- R8: In Load at a block boundary with an empty FIFO, the next state is Idle. `busy` is high whenever the state is not Idle. `idle` is high when the state is Idle and the FIFO is empty.
- R9: A start pulse is accepted only in Idle. A pulse in Load or Wait changes neither the timing nor the mode.
- R10: `clear` is synchronous. After the edge where it is sampled high, the state is Idle and both counters are zero.
- R11: A low `rst_n` at once forces the state to Idle and zeroes both counters, without waiting for a clock edge.
- R12: `fifo_state` encodes Idle as 0, Load as 1 and Wait as 2. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of state and counters |
| cfg_digest | input | 4 | One-hot digest size, 4'b0001 = short mode |
| cfg_hmac | input | 1 | Keyed mode, adds the key-padding interval |
| hash_start | input | 1 | Start pulse, accepted in Idle only |
| fifo_wvalid | input | 1 | Writer offers a word to the FIFO |
| fifo_wready | output | 1 | FIFO can take a word this cycle |
| fifo_rready | output | 1 | Pop strobe toward the FIFO |
| fifo_state | output | 2 | Drain state: 0 Idle, 1 Load, 2 Wait |
| busy | output | 1 | Sequencer is not Idle |
| idle | output | 1 | Idle with an empty FIFO |
| status | output | 10 | Idle, empty, full and depth fields |

## Verification
The hardest situation to reach is a block that ends while the FIFO still holds words, followed by a start pulse that arrives during the stall. Reaching it needs the FIFO pre-filled past one block and a start pulse timed inside the Wait window. Directed sequences fill the FIFO in Idle, start in each mode and measure the length of every Load and Wait run. One of them fires a second start with different settings partway through the key-padding wait. A long constrained-random phase then mixes writes, starts, mode changes and rare clears against a cycle model computed in the bench.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  typedef enum logic [1:0] {
    DRN_IDLE = 2'd0,
    DRN_LOAD = 2'd1,
    DRN_WAIT = 2'd2
  } drain_st_e;

  localparam logic [3:0] DIG_SHORT = 4'b0001;
endpackage

// File: rtl/mfd_level_track.sv
module mfd_level_track #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  output logic [CW-1:0] depth,
  output logic          empty,
  output logic          full
);
  logic [CW-1:0] wr_q, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (clear) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
    end
  end

  assign depth = wr_q - rd_q;
  assign empty = (depth == '0);
  assign full  = (depth == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH)); // R1
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R4
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clear) |=> full); // R1
endmodule

// File: rtl/mfd_mode_sel.sv
module mfd_mode_sel #(
  parameter int BLK_S  = 16,
  parameter int BLK_L  = 32,
  parameter int KEY_S  = 80,
  parameter int KEY_L  = 112,
  parameter int PROC_S = 65,
  parameter int PROC_L = 81,
  parameter int BW     = 5,
  parameter int TW     = 7
) (
  input  logic          long_mode,
  output logic [BW-1:0] blk_last,
  output logic [TW-1:0] key_ticks,
  output logic [TW-1:0] stall_ticks
);
  // Wait lasts (loaded value + 1) cycles; the key interval also covers
  // the cycle in which the start command clears.
  assign blk_last    = long_mode ? BW'(BLK_L - 1)  : BW'(BLK_S - 1);
  assign key_ticks   = long_mode ? TW'(KEY_L)      : TW'(KEY_S);
  assign stall_ticks = long_mode ? TW'(PROC_L - 1) : TW'(PROC_S - 1);
endmodule

// File: rtl/mfd_drain_fsm.sv
module mfd_drain_fsm
  import mfd_pkg::*;
#(
  parameter int BLK_S  = 16,
  parameter int BLK_L  = 32,
  parameter int KEY_S  = 80,
  parameter int KEY_L  = 112,
  parameter int PROC_S = 65,
  parameter int PROC_L = 81,
  localparam int BW   = $clog2(BLK_L),
  localparam int TMAX = (KEY_L > PROC_L) ? KEY_L : PROC_L,
  localparam int TW   = $clog2(TMAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       start,
  input  logic       hmac_en,
  input  logic [3:0] digest,
  input  logic       empty,
  output drain_st_e  state,
  output logic       pop
);
  drain_st_e     st_q, st_d;
  logic [BW-1:0] blk_q, blk_d, blk_last;
  logic [TW-1:0] tmr_q, tmr_d, key_ticks, stall_ticks;
  logic          long_q, long_d, mode_now;

  // In Idle the incoming setting decides; afterwards the captured one.
  assign mode_now = (st_q == DRN_IDLE) ? (digest != DIG_SHORT) : long_q;

  mfd_mode_sel #(
    .BLK_S(BLK_S), .BLK_L(BLK_L), .KEY_S(KEY_S), .KEY_L(KEY_L),
    .PROC_S(PROC_S), .PROC_L(PROC_L), .BW(BW), .TW(TW)
  ) u_mode (
    .long_mode   (mode_now),
    .blk_last    (blk_last),
    .key_ticks   (key_ticks),
    .stall_ticks (stall_ticks)
  );

  assign pop = (st_q == DRN_LOAD) && !empty;

  always_comb begin
    st_d   = st_q;
    blk_d  = blk_q;
    tmr_d  = tmr_q;
    long_d = long_q;
    unique case (st_q)
      DRN_IDLE: begin
        if (start) begin
          long_d = mode_now;
          blk_d  = '0;
          if (hmac_en) begin
            st_d  = DRN_WAIT;
            tmr_d = key_ticks;
          end else begin
            st_d = DRN_LOAD;
          end
        end
      end
      DRN_LOAD: begin
        if (pop) begin
          if (blk_q == blk_last) begin
            blk_d = '0;
            st_d  = DRN_WAIT;
            tmr_d = stall_ticks;
          end else begin
            blk_d = blk_q + 1'b1;
          end
        end else if (blk_q == '0) begin
          st_d = DRN_IDLE;
        end
      end
      DRN_WAIT: begin
        if (tmr_q == '0) st_d = DRN_LOAD;
        else             tmr_d = tmr_q - 1'b1;
      end
      default: st_d = DRN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DRN_IDLE;
      blk_q  <= '0;
      tmr_q  <= '0;
      long_q <= 1'b0;
    end else if (clear) begin
      st_q   <= DRN_IDLE;
      blk_q  <= '0;
      tmr_q  <= '0;
      long_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      blk_q  <= blk_d;
      tmr_q  <= tmr_d;
      long_q <= long_d;
    end
  end

  assign state = st_q;

  AST_BLOCK_END_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && blk_q == blk_last && !clear) |=> st_q == DRN_WAIT); // R5
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DRN_WAIT && tmr_q == '0 && !clear) |=> st_q == DRN_LOAD); // R6
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DRN_IDLE && start && !clear) |=> st_q != DRN_IDLE); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != DRN_IDLE && !clear) |=> $stable(long_q)); // R9
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != 2'd3); // R12
endmodule

// File: rtl/mfd_drain_seq.sv
module mfd_drain_seq
  import mfd_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int BLK_S  = 16,
  parameter int BLK_L  = 32,
  parameter int KEY_S  = 80,
  parameter int KEY_L  = 112,
  parameter int PROC_S = 65,
  parameter int PROC_L = 81,
  localparam int CW = $clog2(DEPTH) + 1,
  localparam int SW = 4 + CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [3:0]    cfg_digest,
  input  logic          cfg_hmac,
  input  logic          hash_start,
  input  logic          fifo_wvalid,
  output logic          fifo_wready,
  output logic          fifo_rready,
  output logic [1:0]    fifo_state,
  output logic          busy,
  output logic          idle,
  output logic [SW-1:0] status
);
  logic [CW-1:0] depth;
  logic          empty, full, pop, push;
  drain_st_e     state;

  assign push = fifo_wvalid && !full;

  mfd_level_track #(.DEPTH(DEPTH)) u_level (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .push  (push),
    .pop   (pop),
    .depth (depth),
    .empty (empty),
    .full  (full)
  );

  mfd_drain_fsm #(
    .BLK_S(BLK_S), .BLK_L(BLK_L), .KEY_S(KEY_S), .KEY_L(KEY_L),
    .PROC_S(PROC_S), .PROC_L(PROC_L)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .start   (hash_start),
    .hmac_en (cfg_hmac),
    .digest  (cfg_digest),
    .empty   (empty),
    .state   (state),
    .pop     (pop)
  );

  assign fifo_wready = !full;
  assign fifo_rready = pop;
  assign fifo_state  = state;
  assign busy        = (state != DRN_IDLE);
  assign idle        = (state == DRN_IDLE) && empty;
  assign status      = {depth, 1'b0, full, empty, idle};

  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !busy); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (status[1:0] == 2'b11)); // R10
endmodule

// File: tb/tb_mfd_drain_seq.sv
`timescale 1ns/1ps
module tb_mfd_drain_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic [3:0] cfg_digest = 4'b0001;
  logic       cfg_hmac = 1'b0;
  logic       hash_start = 1'b0;
  logic       fifo_wvalid = 1'b0;
  logic       fifo_wready, fifo_rready, busy, idle;
  logic [1:0] fifo_state;
  logic [9:0] status;

  always #5 clk = ~clk;

  mfd_drain_seq dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .cfg_digest(cfg_digest),
    .cfg_hmac(cfg_hmac), .hash_start(hash_start), .fifo_wvalid(fifo_wvalid),
    .fifo_wready(fifo_wready), .fifo_rready(fifo_rready),
    .fifo_state(fifo_state), .busy(busy), .idle(idle), .status(status)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Cycle model built from the requirements.
  int m_st, m_wr, m_rd, m_blk, m_tmr, m_d;
  bit m_long, m_pop, m_push;

  function automatic int mdepth();
    return m_wr - m_rd;
  endfunction

  function automatic logic [31:0] exp_status();
    int d = mdepth();
    return (d << 4) | ((d == 32) << 2) | ((d == 0) << 1) | ((m_st == 0 && d == 0) ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || clear) begin
      m_st = 0; m_wr = 0; m_rd = 0; m_blk = 0; m_tmr = 0; m_long = 0;
    end else begin
      m_d    = mdepth();
      m_pop  = (m_st == 1) && (m_d > 0);
      m_push = fifo_wvalid && (m_d < 32);
      case (m_st)
        0: if (hash_start) begin
             m_long = (cfg_digest != 4'b0001);
             m_blk  = 0;
             if (cfg_hmac) begin m_st = 2; m_tmr = m_long ? 112 : 80; end
             else m_st = 1;
           end
        1: if (m_pop) begin
             if (m_blk == (m_long ? 31 : 15)) begin
               m_blk = 0; m_st = 2; m_tmr = (m_long ? 81 : 65) - 1;
             end else m_blk++;
           end else if (m_blk == 0) m_st = 0;
        default: if (m_tmr == 0) m_st = 1; else m_tmr--;
      endcase
      if (m_push) m_wr++;
      if (m_pop)  m_rd++;
    end
  end

  bit cmp_en = 1'b0;
  always @(negedge clk) if (cmp_en) begin
    chk("R2 status", 32'(status), exp_status());
    chk("R4 rready", 32'(fifo_rready), 32'((m_st == 1) && (mdepth() > 0)));
    chk("R12 state", 32'(fifo_state), 32'(m_st));
    chk("R1 wready", 32'(fifo_wready), 32'(mdepth() < 32));
    chk("R8 busy", 32'(busy), 32'(m_st != 0));
  end

  task automatic push_n(input int k);
    fifo_wvalid = 1'b1;
    repeat (k) @(negedge clk);
    fifo_wvalid = 1'b0;
  endtask

  task automatic start_pulse(input logic [3:0] dig, input logic h);
    cfg_digest = dig; cfg_hmac = h; hash_start = 1'b1;
    @(negedge clk);
    hash_start = 1'b0;
  endtask

  task automatic run_len(input logic [1:0] s, output int n);
    n = 0;
    while (fifo_state == s && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (fifo_state != 2'd0 && g < 2000) begin g++; @(negedge clk); end
  endtask

  initial begin
    #(100000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_en = 1'b1;
    // R11 reset state
    chk("R11 reset status", 32'(status), 32'h003);
    chk("R11 reset state", 32'(fifo_state), 0);

    // R1: overfill in Idle
    push_n(33);
    chk("R1 full status", 32'(status), 32'h204);
    chk("R1 wready low", 32'(fifo_wready), 0);

    // Short mode, no key
    start_pulse(4'b0001, 1'b0);
    run_len(2'd1, n); chk("R5 short block", n, 16);
    run_len(2'd2, n); chk("R6 short stall", n, 65);
    run_len(2'd1, n); chk("R5 short block 2", n, 16);
    run_len(2'd2, n); chk("R6 short stall 2", n, 65);
    run_len(2'd1, n); chk("R8 empty boundary", n, 1);
    chk("R8 idle status", 32'(status), 32'h003);

    // Long mode with key padding, digest 4'b0100
    push_n(32);
    start_pulse(4'b0100, 1'b1);
    run_len(2'd2, n); chk("R7 long key pad", n, 113);
    run_len(2'd1, n); chk("R5 long block", n, 32);
    run_len(2'd2, n); chk("R6 long stall", n, 81);
    run_len(2'd1, n); chk("R8 long end", n, 1);

    // Short keyed, second start during wait is ignored
    push_n(16);
    start_pulse(4'b0001, 1'b1);
    repeat (10) @(negedge clk);
    start_pulse(4'b0100, 1'b0);
    run_len(2'd2, n); chk("R9 key pad unchanged", n, 70);
    run_len(2'd1, n); chk("R9 mode kept", n, 16);
    run_len(2'd2, n); chk("R6 stall after keyed", n, 65);
    wait_idle();

    // R3: non one-hot value selects long mode
    push_n(40);
    start_pulse(4'b0000, 1'b0);
    run_len(2'd1, n); chk("R3 zero digest long", n, 32);
    wait_idle();

    // R4: Load mid-block with empty FIFO holds, no pop
    push_n(4);
    start_pulse(4'b0001, 1'b0);
    repeat (6) @(negedge clk);
    chk("R4 load held", 32'(fifo_state), 1);
    chk("R4 no pop when empty", 32'(fifo_rready), 0);
    push_n(12);
    run_len(2'd1, n);
    chk("R5 block completes", 32'(fifo_state), 2);
    wait_idle();

    // R10: synchronous clear mid-load
    push_n(8);
    start_pulse(4'b0001, 1'b0);
    repeat (2) @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk("R10 clear state", 32'(fifo_state), 0);
    chk("R10 clear status", 32'(status), 32'h003);

    // R11: asynchronous reset mid-run
    push_n(5);
    start_pulse(4'b0001, 1'b1);
    repeat (2) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R11 async status", 32'(status), 32'h003);
    chk("R11 async state", 32'(fifo_state), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Constrained random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20000; i++) begin
      int r = int'($urandom_range(0, 99));
      fifo_wvalid = (r < 45);
      hash_start  = ($urandom_range(0, 39) == 0);
      cfg_hmac    = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 4))
        0: cfg_digest = 4'b0001;
        1: cfg_digest = 4'b0010;
        2: cfg_digest = 4'b0100;
        3: cfg_digest = 4'b1000;
        default: cfg_digest = 4'($urandom_range(0, 15));
      endcase
      clear = ($urandom_range(0, 499) == 0);
      @(negedge clk);
    end
    fifo_wvalid = 1'b0; hash_start = 1'b0; clear = 1'b0;
    @(negedge clk);
    cmp_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule